// File: doc/BRIEF.md
# Boot ROM Overlay Memory Decoder

This block is the memory-map decoder for an 8-bit processor that has a 16-bit address bus and a separate I/O space. When reset is released, memory reads in the low half of the map (address bit 15 clear) go to a boot ROM. Memory writes to the same addresses go to the RAM that sits under the ROM. Boot code can therefore read each ROM byte and write it back to the same address, which leaves a copy of itself in RAM.

When the copy is complete, the boot code makes one I/O write to a fixed port. That write flips a single map bit, and from then on the low half is plain RAM for reads and for writes. The port decode looks only at the low address byte. The block has no data input, so the value written is never seen. Each write to the port inverts the map bit. The upper half of the map is RAM at all times. The outputs are an active-low ROM chip select, an active-low RAM chip select and an active-low RAM write enable. The memory arrays themselves are not part of the block.

Top module: `boot_overlay_decoder`

## Requirements
- R1: After reset the block is in overlay mode. In overlay mode, a memory read (mreq_n=0, rd_n=0, wr_n=1) with addr[15]=0 drives rom_cs_n=0, ram_cs_n=1 and ram_we_n=1.
- R2: In overlay mode, a memory write (mreq_n=0, wr_n=0, rd_n=1) with addr[15]=0 drives ram_cs_n=0 and ram_we_n=0, and rom_cs_n stays at 1.
- R3: When addr[15]=1, a memory read selects RAM with ram_we_n=1, and a memory write selects RAM with ram_we_n=0. This holds in both modes, and rom_cs_n is never 0 while addr[15]=1.
- R4: An I/O write (iorq_n=0, wr_n=0) whose addr[7:0] equals 8'h23 inverts the mode bit. The upper address byte can hold any value. The new mode takes effect at the first rising clock edge on which the strobe pair is no longer active. Until that edge, decoding uses the old mode.
- R5: A second write to the port inverts the mode bit again, which puts the block back in overlay mode. The mode bit toggles on each such write and is never loaded from the bus.
- R6: The mode bit does not change on any of the following: an I/O write to any other low byte, an I/O read of port 8'h23, or a memory write whose address low byte is 8'h23.
- R7: While mreq_n=1, all three outputs are 1. This covers every I/O cycle.
- R8: rom_cs_n and ram_cs_n are never both 0. ram_we_n=0 only happens together with ram_cs_n=0. A memory cycle with rd_n=0 and wr_n=0 at the same time selects nothing.
- R9: Outside overlay mode, a memory read with addr[15]=0 drives ram_cs_n=0, ram_we_n=1 and rom_cs_n=1. RAM contents copied during overlay mode read back unchanged.
- R10: Driving rst_n low returns the block to overlay mode at once, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that samples the I/O strobes |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | Processor address bus |
| mreq_n | input | 1 | Memory request, active low |
| iorq_n | input | 1 | I/O request, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| rom_cs_n | output | 1 | Boot ROM chip select, active low |
| ram_cs_n | output | 1 | RAM chip select, active low |
| ram_we_n | output | 1 | RAM write enable, active low |

## Verification
The three select outputs are combinational functions of the bus and the mode bit. The bench therefore drives each memory cycle just after a falling clock edge and compares the outputs 2 ns later, in the same half-period, with no clock edge in between.

A mode change takes two register stages: one samples the strobe and one holds the mode. The bench releases the port write at a falling edge and probes the map before the next rising edge, where it must still see the old mode. It probes again after that rising edge, where it must see the new mode. Reset is checked 1 ns after rst_n falls, in the middle of a cycle, with no clock edge between the fall and the check.

// File: rtl/boot_overlay_pkg.sv
package boot_overlay_pkg;

  // Active-high selection produced by the memory decode.
  typedef struct packed {
    logic rom;
    logic ram;
    logic we;
  } mem_sel_t;

  // A cycle is a clean read only with exactly one strobe low.
  function automatic logic clean_read(input logic rd_n, input logic wr_n);
    return ~rd_n & wr_n;
  endfunction

  function automatic logic clean_write(input logic rd_n, input logic wr_n);
    return ~wr_n & rd_n;
  endfunction

  // Map decode: the ROM answers only low-half reads while the overlay is on.
  function automatic mem_sel_t decode_map(input logic overlay,
                                          input logic upper,
                                          input logic mem_act,
                                          input logic rd,
                                          input logic wr);
    mem_sel_t s;
    s.rom = mem_act & rd & ~upper & overlay;
    s.ram = mem_act & (rd | wr) & ~s.rom;
    s.we  = s.ram & wr;
    return s;
  endfunction

endpackage

// File: rtl/boot_overlay_port_dec.sv
module boot_overlay_port_dec #(
  parameter int unsigned PORT_W = 8,
  parameter logic [PORT_W-1:0] PORT_ADDR = 8'h23
) (
  input  logic [PORT_W-1:0] port_addr,
  input  logic              iorq_n,
  input  logic              wr_n,
  output logic              io_wr_active,
  output logic              port_hit
);
  // An I/O write in progress; the port compare uses the low byte only.
  assign io_wr_active = ~iorq_n & ~wr_n;
  assign port_hit     = io_wr_active & (port_addr == PORT_ADDR);
endmodule

// File: rtl/boot_overlay_mode.sv
module boot_overlay_mode (
  input  logic clk,
  input  logic rst_n,
  input  logic port_hit,
  input  logic io_wr_active,
  output logic overlay_q,
  output logic toggle_evt
);
  logic hit_q;

  // Trailing edge of a port write: the strobe was on the port and is now gone.
  assign toggle_evt = hit_q & ~io_wr_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q     <= 1'b0;
      overlay_q <= 1'b1;
    end else begin
      hit_q <= port_hit;
      if (toggle_evt) overlay_q <= ~overlay_q;
    end
  end
endmodule

// File: rtl/boot_overlay_mem_dec.sv
module boot_overlay_mem_dec
  import boot_overlay_pkg::*;
(
  input  logic overlay,
  input  logic upper,
  input  logic mreq_n,
  input  logic rd_n,
  input  logic wr_n,
  output logic rom_cs_n,
  output logic ram_cs_n,
  output logic ram_we_n
);
  mem_sel_t sel;

  always_comb begin
    sel = decode_map(overlay, upper, ~mreq_n,
                     clean_read(rd_n, wr_n), clean_write(rd_n, wr_n));
  end

  assign rom_cs_n = ~sel.rom;
  assign ram_cs_n = ~sel.ram;
  assign ram_we_n = ~sel.we;
endmodule

// File: rtl/boot_overlay_decoder.sv
module boot_overlay_decoder #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned PORT_W = 8,
  parameter logic [PORT_W-1:0] PORT_ADDR = 8'h23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              mreq_n,
  input  logic              iorq_n,
  input  logic              rd_n,
  input  logic              wr_n,
  output logic              rom_cs_n,
  output logic              ram_cs_n,
  output logic              ram_we_n
);
  localparam int unsigned HALF_BIT = ADDR_W - 1;

  // Named internal events, visible to the bound checker.
  logic overlay_q;
  logic toggle_evt;
  logic port_hit;
  logic io_wr_active;
  logic upper_half;

  // Middle address bits play no part in either decode.
  logic unused_mid_addr;
  assign unused_mid_addr = ^addr[HALF_BIT-1:PORT_W];

  assign upper_half = addr[HALF_BIT];

  boot_overlay_port_dec #(
    .PORT_W   (PORT_W),
    .PORT_ADDR(PORT_ADDR)
  ) port_dec_i (
    .port_addr   (addr[PORT_W-1:0]),
    .iorq_n      (iorq_n),
    .wr_n        (wr_n),
    .io_wr_active(io_wr_active),
    .port_hit    (port_hit)
  );

  boot_overlay_mode mode_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .port_hit    (port_hit),
    .io_wr_active(io_wr_active),
    .overlay_q   (overlay_q),
    .toggle_evt  (toggle_evt)
  );

  boot_overlay_mem_dec mem_dec_i (
    .overlay (overlay_q),
    .upper   (upper_half),
    .mreq_n  (mreq_n),
    .rd_n    (rd_n),
    .wr_n    (wr_n),
    .rom_cs_n(rom_cs_n),
    .ram_cs_n(ram_cs_n),
    .ram_we_n(ram_we_n)
  );
endmodule

// File: rtl/boot_overlay_decoder_chk.sv
module boot_overlay_decoder_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned PORT_W = 8,
  parameter logic [PORT_W-1:0] PORT_ADDR = 8'h23
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              mreq_n,
  input logic              iorq_n,
  input logic              rd_n,
  input logic              wr_n,
  input logic              rom_cs_n,
  input logic              ram_cs_n,
  input logic              ram_we_n,
  input logic              overlay_q,
  input logic              toggle_evt
);
  // R8: never two devices on the bus
  p_cs_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rom_cs_n && !ram_cs_n));

  // R8: write enable only with the RAM selected
  p_we_needs_cs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_we_n |-> !ram_cs_n);

  // R3: the ROM stays silent in the upper half
  p_no_rom_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
    addr[ADDR_W-1] |-> rom_cs_n);

  // R7: no memory request, no select
  p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_n |-> (rom_cs_n && ram_cs_n && ram_we_n));

  // R2: the ROM answers only clean reads in overlay mode
  p_rom_read_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_cs_n |-> (!rd_n && wr_n && overlay_q));

  // R4: a trailing-edge event flips the mode at the next edge
  p_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    toggle_evt |=> (overlay_q != $past(overlay_q)));

  // R4: an event needs a port write seen at the previous edge
  p_toggle_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    toggle_evt |-> $past(!iorq_n && !wr_n && (addr[PORT_W-1:0] == PORT_ADDR)));

  // R6: without an event the mode holds
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !toggle_evt |=> $stable(overlay_q));
endmodule

bind boot_overlay_decoder boot_overlay_decoder_chk #(
  .ADDR_W(ADDR_W), .PORT_W(PORT_W), .PORT_ADDR(PORT_ADDR)
) chk_i (
  .clk(clk), .rst_n(rst_n), .addr(addr), .mreq_n(mreq_n), .iorq_n(iorq_n),
  .rd_n(rd_n), .wr_n(wr_n), .rom_cs_n(rom_cs_n), .ram_cs_n(ram_cs_n),
  .ram_we_n(ram_we_n), .overlay_q(overlay_q), .toggle_evt(toggle_evt)
);

// File: tb/boot_overlay_decoder_tb_top.sv
module boot_overlay_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic        mreq_n = 1'b1, iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic        rom_cs_n, ram_cs_n, ram_we_n;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  logic [7:0] ram [256];

  always #10 clk = ~clk;

  boot_overlay_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .mreq_n(mreq_n), .iorq_n(iorq_n),
    .rd_n(rd_n), .wr_n(wr_n), .rom_cs_n(rom_cs_n), .ram_cs_n(ram_cs_n),
    .ram_we_n(ram_we_n)
  );

  function automatic logic [7:0] rom_byte(input logic [15:0] a);
    return (a[7:0] * 8'd7) ^ 8'h3C;
  endfunction

  function automatic logic [7:0] ram_idx(input logic [15:0] a);
    return {a[15], a[6:0]};
  endfunction

  // Expected {rom_cs_n, ram_cs_n, ram_we_n} restated from the requirements.
  function automatic logic [2:0] expect_sel(input logic ov, input logic [15:0] a,
                                            input logic mq, input logic r, input logic w);
    logic rd_ok, wr_ok;
    rd_ok = !mq && !r && w;
    wr_ok = !mq && !w && r;
    if (rd_ok && !a[15] && ov) return 3'b011;
    if (rd_ok) return 3'b101;
    if (wr_ok) return 3'b100;
    return 3'b111;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic go_idle();
    mreq_n = 1'b1; iorq_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
  endtask

  // Drive one memory cycle and return the sampled selects.
  task automatic mem_cycle(input logic [15:0] a, input logic mq, input logic r,
                           input logic w, output logic [2:0] sel);
    @(negedge clk);
    addr = a; mreq_n = mq; rd_n = r; wr_n = w;
    #2;
    sel = {rom_cs_n, ram_cs_n, ram_we_n};
    #2;
    go_idle();
  endtask

  task automatic mem_read(input logic [15:0] a, output logic [2:0] sel,
                          output logic [7:0] d);
    @(negedge clk);
    addr = a; mreq_n = 1'b0; rd_n = 1'b0;
    #2;
    sel = {rom_cs_n, ram_cs_n, ram_we_n};
    d = !rom_cs_n ? rom_byte(a) : (!ram_cs_n ? ram[ram_idx(a)] : 8'h00);
    #2;
    go_idle();
  endtask

  task automatic mem_write(input logic [15:0] a, input logic [7:0] d,
                           output logic [2:0] sel);
    @(negedge clk);
    addr = a; mreq_n = 1'b0; wr_n = 1'b0;
    #2;
    sel = {rom_cs_n, ram_cs_n, ram_we_n};
    if (!ram_cs_n && !ram_we_n) ram[ram_idx(a)] = d;
    #2;
    go_idle();
  endtask

  // I/O cycle; returns the map seen just after release, before the next rising edge.
  task automatic io_cycle(input logic [15:0] a, input bit is_wr, output logic pre_rom);
    @(negedge clk);
    addr = a; iorq_n = 1'b0;
    if (is_wr) wr_n = 1'b0; else rd_n = 1'b0;
    #2;
    check({rom_cs_n, ram_cs_n, ram_we_n} == 3'b111, "R7", "selects during I/O",
          {rom_cs_n, ram_cs_n, ram_we_n}, 3'b111);
    @(negedge clk);
    go_idle();
    #2;
    addr = 16'h0010; mreq_n = 1'b0; rd_n = 1'b0;
    #1;
    pre_rom = rom_cs_n;
    #1;
    go_idle();
    @(posedge clk);
  endtask

  task automatic probe_overlay(input bit exp_ov, input string req);
    logic [2:0] s;
    mem_cycle(16'h0010, 1'b0, 1'b0, 1'b1, s);
    check(s[2] == !exp_ov, req, "map probe rom_cs_n", s[2], !exp_ov);
  endtask

  task automatic sweep(input bit ov);
    logic [15:0] pts [6];
    logic [2:0] s, e;
    string req;
    pts = '{16'h0000, 16'h0023, 16'h4123, 16'h7FFF, 16'h8000, 16'hFFFF};
    for (int i = 0; i < 6; i++) begin
      for (int c = 0; c < 8; c++) begin
        mem_cycle(pts[i], c[2], c[1], c[0], s);
        e = expect_sel(ov, pts[i], c[2], c[1], c[0]);
        if (c[2]) req = "R7";
        else if (pts[i][15]) req = "R3";
        else if (!c[1] && c[0]) req = ov ? "R1" : "R9";
        else if (!c[0] && c[1]) req = "R2";
        else req = "R8";
        check(s == e, req, "sweep selects", s, e);
      end
    end
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 50000) begin
        n_bad++;
        $display("FAIL watchdog expired after %0d cycles", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin : stim
    logic [2:0] s;
    logic [7:0] d;
    logic pre;
    for (int i = 0; i < 256; i++) ram[i] = 8'h00;

    // Reset state
    repeat (3) @(negedge clk);
    check({rom_cs_n, ram_cs_n, ram_we_n} == 3'b111, "R7", "idle in reset",
          {rom_cs_n, ram_cs_n, ram_we_n}, 3'b111);
    rst_n = 1'b1;
    probe_overlay(1'b1, "R1");
    sweep(1'b1);

    // Boot copy in overlay mode: read ROM, write the byte back to RAM
    for (int a = 0; a < 128; a++) begin
      mem_read(a[15:0], s, d);
      check(s == 3'b011, "R1", "copy read selects", s, 3'b011);
      check(d == rom_byte(a[15:0]), "R1", "copy read data", d, rom_byte(a[15:0]));
      mem_write(a[15:0], d, s);
      check(s == 3'b100, "R2", "copy write selects (ROM never written)", s, 3'b100);
    end

    // Cycles that must leave the mode alone
    io_cycle(16'h0022, 1'b1, pre);
    probe_overlay(1'b1, "R6");
    io_cycle(16'h2324, 1'b1, pre);
    probe_overlay(1'b1, "R6");
    io_cycle(16'h0023, 1'b0, pre);
    probe_overlay(1'b1, "R6");
    mem_write(16'h0023, rom_byte(16'h0023), s);
    probe_overlay(1'b1, "R6");

    // Port write with a nonzero upper byte flips the map after release
    io_cycle(16'hA523, 1'b1, pre);
    check(pre == 1'b0, "R4", "old map kept before rising edge", pre, 1'b0);
    probe_overlay(1'b0, "R4");

    // Copied data now read from RAM
    for (int a = 0; a < 128; a++) begin
      mem_read(a[15:0], s, d);
      check(s == 3'b101, "R9", "RAM-mode read selects", s, 3'b101);
      check(d == rom_byte(a[15:0]), "R9", "copied data", d, rom_byte(a[15:0]));
    end
    mem_write(16'h0005, 8'h5A, s);
    mem_read(16'h0005, s, d);
    check(d == 8'h5A, "R9", "low RAM write/read back", d, 8'h5A);
    mem_write(16'h8005, 8'hC3, s);
    mem_read(16'h8005, s, d);
    check(d == 8'hC3 && s == 3'b101, "R3", "upper RAM read back", {s, d}, {3'b101, 8'hC3});

    sweep(1'b0);

    // Second port write restores the overlay
    io_cycle(16'h0023, 1'b1, pre);
    check(pre == 1'b1, "R4", "RAM map kept before rising edge", pre, 1'b1);
    probe_overlay(1'b1, "R5");
    io_cycle(16'hFF23, 1'b1, pre);
    probe_overlay(1'b0, "R5");

    // Asynchronous reset in mid-cycle returns to overlay
    @(negedge clk);
    addr = 16'h0010; mreq_n = 1'b0; rd_n = 1'b0;
    #2;
    check(rom_cs_n == 1'b1, "R10", "RAM map before reset", rom_cs_n, 1'b1);
    rst_n = 1'b0;
    #1;
    check(rom_cs_n == 1'b0, "R10", "overlay right after reset", rom_cs_n, 1'b0);
    go_idle();
    @(negedge clk);
    rst_n = 1'b1;
    probe_overlay(1'b1, "R10");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule